// File: doc/BRIEF.md
# Ping-Pong Buffer Address Sequencer

This block produces the memory write address for a transfer channel that fills two separate buffers in turn. Each buffer has its own base-address register. A one-bit target flag names the buffer being filled. Each strobe on the advance input moves the address forward by one item. When the programmed number of items has gone into the active buffer, the block jumps to the other buffer's base, flips the target flag and pulses a completion output for one cycle. Software then drains the buffer that was just filled while the other one fills.

The two buffers are independent, so they can sit anywhere in the address map. While the channel runs, software may point the idle buffer at a new location, and the new base is used at the next switch. Writes that would disturb the buffer being filled, or the item count, are refused while the channel runs, and a sticky error flag records each refusal. Moving the data and handshaking with peripherals happen outside this block.

Top module: `dbuf_addr_unit`

## Requirements
- R1: While reset is high, and in the cycle after it, the address is 0, the target flag is 0, and the completion, error and running outputs are low.
- R2: A write to register select 3 (control) with data bit 0 = 1 while stopped starts the channel. Data bit 1 picks the first buffer (0 or 1), the item index becomes 0, and the address becomes that buffer's base in the next cycle.
- R3: While running, each advance strobe raises the address by ITEM_BYTES in the next cycle. The address is always base[target] + index * ITEM_BYTES.
- R4: The advance that completes the programmed count switches buffers. In the next cycle the target flag is inverted, the index is 0, the address is the other buffer's base, and the completion output is high for that cycle alone.
- R5: Register selects 0 and 1 hold the bases of buffers 0 and 1. A write to the inactive buffer's base while running is accepted and is used at the next switch, including a switch in the same cycle as the write.
- R6: A write to the active buffer's base while running is refused. The stored base is unchanged and the error output goes high and stays high until the next control write.
- R7: A write to register select 2 (item count, low CNT_W bits) while running is refused and sets the error output.
- R8: An advance strobe while stopped has no effect on the address, the target flag or the completion output.
- R9: A control write with bit 0 = 0 stops the channel and clears the error output. The address and target are kept.
- R10: With a count of 1, every advance switches buffers and pulses completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 base 0, 1 base 1, 2 count, 3 control |
| wr_data | input | ADDR_W | Write data |
| advance | input | 1 | One item has been written at the current address |
| wr_addr | output | ADDR_W | Current item address |
| cur_tgt | output | 1 | Buffer being filled |
| xfer_done | output | 1 | One-cycle pulse on each buffer switch |
| wr_err | output | 1 | Sticky flag for a refused write |
| running | output | 1 | Channel enabled |

## Verification
The hardest case to reach is a write to the idle buffer's base that lands in the same cycle as the advance that causes a switch. The address must then take the new base, not the old one. The bench sets the count to 1, so every advance is a switch, and issues the base write and the advance together. It also retargets the idle buffer one item before a switch, and writes to the active buffer right after a switch, to check that the refusal follows the target flag.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;

  typedef enum logic [1:0] {
    SEL_BASE0 = 2'd0,
    SEL_BASE1 = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_CTRL  = 2'd3
  } reg_sel_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_TGT_BIT = 1;

endpackage

// File: rtl/dbuf_regs.sv
module dbuf_regs
  import dbuf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [1:0]             wr_sel,
  input  logic [ADDR_W-1:0]      wr_data,
  input  logic                   run_q,
  input  logic                   tgt_q,
  output logic [1:0][ADDR_W-1:0] base_nxt,
  output logic [CNT_W-1:0]       cnt_q,
  output logic                   err_q
);

  logic [1:0][ADDR_W-1:0] base_q;
  logic [1:0]             base_rej;
  logic                   cnt_hit, cnt_rej, ctl_hit;

  genvar gi;
  generate
    for (gi = 0; gi < 2; gi++) begin : g_base
      logic hit;
      assign hit          = wr_en && (wr_sel == 2'(gi));
      assign base_rej[gi] = hit && run_q && (tgt_q == 1'(gi));
      assign base_nxt[gi] = (hit && !base_rej[gi]) ? wr_data : base_q[gi];

      always_ff @(posedge clk) begin
        if (rst) base_q[gi] <= '0;
        else     base_q[gi] <= base_nxt[gi];
      end

      AST_ACTIVE_BASE_KEPT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'(gi) && run_q && tgt_q == 1'(gi))
        |=> (base_q[gi] == $past(base_q[gi])) && err_q); // R6
    end
  endgenerate

  assign cnt_hit = wr_en && (wr_sel == SEL_COUNT);
  assign cnt_rej = cnt_hit && run_q;
  assign ctl_hit = wr_en && (wr_sel == SEL_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (cnt_hit && !cnt_rej) cnt_q <= wr_data[CNT_W-1:0];
      if (ctl_hit)                       err_q <= 1'b0;
      else if (cnt_rej || (|base_rej))   err_q <= 1'b1;
    end
  end

  AST_CNT_KEPT_RUN: assert property (@(posedge clk) disable iff (rst)
    (cnt_hit && run_q) |=> (cnt_q == $past(cnt_q)) && err_q); // R7

endmodule

// File: rtl/dbuf_seq.sv
module dbuf_seq #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic             ctl_en,
  input  logic             ctl_tgt,
  input  logic             advance,
  input  logic [CNT_W-1:0] cnt_q,
  output logic             run_q,
  output logic             tgt_q,
  output logic [CNT_W-1:0] idx_q,
  output logic             tgt_nxt,
  output logic [CNT_W-1:0] idx_nxt,
  output logic             done_q
);

  logic run_nxt, start, step, last, wrap;

  assign run_nxt = ctl_wr ? ctl_en : run_q;
  assign start   = ctl_wr && ctl_en && !run_q;
  assign step    = advance && run_q && run_nxt;
  assign last    = (idx_q == cnt_q - CNT_W'(1));
  assign wrap    = step && last;

  always_comb begin
    tgt_nxt = tgt_q;
    idx_nxt = idx_q;
    if (start) begin
      tgt_nxt = ctl_tgt;
      idx_nxt = '0;
    end else if (wrap) begin
      tgt_nxt = ~tgt_q;
      idx_nxt = '0;
    end else if (step) begin
      idx_nxt = idx_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      tgt_q  <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_nxt;
      tgt_q  <= tgt_nxt;
      idx_q  <= idx_nxt;
      done_q <= wrap;
    end
  end

  AST_FLIP_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (tgt_q != $past(tgt_q))); // R4
  AST_IDX_ZERO_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (idx_q == '0)); // R4
  AST_IDLE_NO_STEP: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !ctl_wr) |=> $stable(idx_q) && $stable(tgt_q) && !done_q); // R8

endmodule

// File: rtl/dbuf_addr_gen.sv
module dbuf_addr_gen #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int ITEM_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0][ADDR_W-1:0] base_nxt,
  input  logic                   tgt_nxt,
  input  logic [CNT_W-1:0]       idx_nxt,
  output logic [ADDR_W-1:0]      addr_q
);

  localparam bit IS_POW2 = ((ITEM_BYTES & (ITEM_BYTES - 1)) == 0);
  localparam int SHIFT   = $clog2(ITEM_BYTES);

  logic [ADDR_W-1:0] offset;

  generate
    if (IS_POW2) begin : g_shift
      assign offset = ADDR_W'(idx_nxt) << SHIFT;
    end else begin : g_mult
      assign offset = ADDR_W'(idx_nxt) * ADDR_W'(ITEM_BYTES);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else     addr_q <= base_nxt[tgt_nxt] + offset;
  end

endmodule

// File: rtl/dbuf_addr_unit.sv
module dbuf_addr_unit
  import dbuf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int ITEM_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              advance,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              cur_tgt,
  output logic              xfer_done,
  output logic              wr_err,
  output logic              running
);

  logic [1:0][ADDR_W-1:0] base_nxt;
  logic [CNT_W-1:0]       cnt_q, idx_q, idx_nxt;
  logic                   tgt_nxt, ctl_wr;

  assign ctl_wr = wr_en && (wr_sel == SEL_CTRL);

  dbuf_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .run_q(running), .tgt_q(cur_tgt), .base_nxt(base_nxt), .cnt_q(cnt_q),
    .err_q(wr_err)
  );

  dbuf_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr),
    .ctl_en(wr_data[CTRL_EN_BIT]), .ctl_tgt(wr_data[CTRL_TGT_BIT]),
    .advance(advance), .cnt_q(cnt_q), .run_q(running), .tgt_q(cur_tgt),
    .idx_q(idx_q), .tgt_nxt(tgt_nxt), .idx_nxt(idx_nxt), .done_q(xfer_done)
  );

  dbuf_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .ITEM_BYTES(ITEM_BYTES)) u_addr (
    .clk(clk), .rst(rst), .base_nxt(base_nxt), .tgt_nxt(tgt_nxt),
    .idx_nxt(idx_nxt), .addr_q(wr_addr)
  );

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (running && advance && !wr_en)
    |=> xfer_done || (wr_addr == $past(wr_addr) + ADDR_W'(ITEM_BYTES))); // R3
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (running && cnt_q != '0) |-> (idx_q < cnt_q)); // R4

endmodule

// File: tb/dbuf_addr_unit_test.sv
`timescale 1ns/1ps
module dbuf_addr_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic        advance = 1'b0;
  logic [31:0] wr_addr;
  logic        cur_tgt, xfer_done, wr_err, running;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dbuf_addr_unit #(.ADDR_W(32), .CNT_W(16), .ITEM_BYTES(4)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .advance(advance), .wr_addr(wr_addr), .cur_tgt(cur_tgt),
    .xfer_done(xfer_done), .wr_err(wr_err), .running(running)
  );

  typedef struct packed {
    logic        we;
    logic [1:0]  sel;
    logic [31:0] dat;
    logic        adv;
    logic [31:0] ea;
    logic        et;
    logic        ed;
    logic        ee;
    logic        er;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd0, 32'h0000_1000, 1'b0, 32'h0000_1000, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 base0 idle
    '{1'b1, 2'd1, 32'h8000_0040, 1'b0, 32'h0000_1000, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 base1 idle
    '{1'b1, 2'd2, 32'd3,         1'b0, 32'h0000_1000, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 count idle
    '{1'b1, 2'd3, 32'd1,         1'b0, 32'h0000_1000, 1'b0, 1'b0, 1'b0, 1'b1}, // R2 start tgt0
    '{1'b0, 2'd0, 32'd0,         1'b1, 32'h0000_1004, 1'b0, 1'b0, 1'b0, 1'b1}, // R3
    '{1'b0, 2'd0, 32'd0,         1'b1, 32'h0000_1008, 1'b0, 1'b0, 1'b0, 1'b1}, // R3
    '{1'b0, 2'd0, 32'd0,         1'b1, 32'h8000_0040, 1'b1, 1'b1, 1'b0, 1'b1}, // R4 switch
    '{1'b0, 2'd0, 32'd0,         1'b0, 32'h8000_0040, 1'b1, 1'b0, 1'b0, 1'b1}, // R4 pulse ends
    '{1'b1, 2'd0, 32'h0000_2000, 1'b1, 32'h8000_0044, 1'b1, 1'b0, 1'b0, 1'b1}, // R5 idle base
    '{1'b0, 2'd0, 32'd0,         1'b1, 32'h8000_0048, 1'b1, 1'b0, 1'b0, 1'b1}, // R3
    '{1'b0, 2'd0, 32'd0,         1'b1, 32'h0000_2000, 1'b0, 1'b1, 1'b0, 1'b1}, // R5 new base used
    '{1'b1, 2'd0, 32'h0000_3000, 1'b0, 32'h0000_2000, 1'b0, 1'b0, 1'b1, 1'b1}, // R6 refused
    '{1'b0, 2'd0, 32'd0,         1'b1, 32'h0000_2004, 1'b0, 1'b0, 1'b1, 1'b1}, // R6 base kept
    '{1'b1, 2'd2, 32'd5,         1'b0, 32'h0000_2004, 1'b0, 1'b0, 1'b1, 1'b1}, // R7 refused
    '{1'b1, 2'd3, 32'd0,         1'b0, 32'h0000_2004, 1'b0, 1'b0, 1'b0, 1'b0}, // R9 stop
    '{1'b0, 2'd0, 32'd0,         1'b1, 32'h0000_2004, 1'b0, 1'b0, 1'b0, 1'b0}  // R8 ignored
  };

  function automatic string rq_of(int i);
    case (i)
      0, 1, 8, 10: return "R5";
      2, 13:       return "R7";
      3:           return "R2";
      6, 7:        return "R4";
      11, 12:      return "R6";
      14:          return "R9";
      15:          return "R8";
      default:     return "R3";
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic apply(logic we, logic [1:0] sel, logic [31:0] dat, logic adv);
    @(negedge clk);
    wr_en = we; wr_sel = sel; wr_data = dat; advance = adv;
    @(posedge clk);
    #2;
    wr_en = 1'b0; advance = 1'b0;
  endtask

  task automatic expect_all(string req, logic [31:0] ea, logic et, logic ed,
                            logic ee, logic er);
    check(req, "wr_addr", wr_addr, ea);
    check(req, "cur_tgt", 32'(cur_tgt), 32'(et));
    check(req, "xfer_done", 32'(xfer_done), 32'(ed));
    check(req, "wr_err", 32'(wr_err), 32'(ee));
    check(req, "running", 32'(running), 32'(er));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #2;
    expect_all("R1", 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #2;
    expect_all("R1", 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].we, VEC[i].sel, VEC[i].dat, VEC[i].adv);
      expect_all(rq_of(i), VEC[i].ea, VEC[i].et, VEC[i].ed, VEC[i].ee, VEC[i].er);
    end

    // R1: reset in mid-operation returns every output to idle
    apply(1'b1, 2'd3, 32'd1, 1'b0);
    do_reset();

    // R2: start with buffer 1 as the first target
    apply(1'b1, 2'd0, 32'h0000_0100, 1'b0);
    apply(1'b1, 2'd1, 32'h0000_0200, 1'b0);
    apply(1'b1, 2'd2, 32'd1, 1'b0);
    apply(1'b1, 2'd3, 32'd3, 1'b0);
    expect_all("R2", 32'h0000_0200, 1'b1, 1'b0, 1'b0, 1'b1);

    // R10: count of one switches on every advance
    apply(1'b0, 2'd0, 32'd0, 1'b1);
    expect_all("R10", 32'h0000_0100, 1'b0, 1'b1, 1'b0, 1'b1);

    // R5: idle-base write in the same cycle as a switch lands immediately
    apply(1'b1, 2'd1, 32'h0000_0400, 1'b1);
    expect_all("R5", 32'h0000_0400, 1'b1, 1'b1, 1'b0, 1'b1);

    // R4: completion drops after one cycle without an advance
    apply(1'b0, 2'd0, 32'd0, 1'b0);
    expect_all("R4", 32'h0000_0400, 1'b1, 1'b0, 1'b0, 1'b1);

    // R6: now buffer 1 is active, so a base1 write is refused
    apply(1'b1, 2'd1, 32'h0000_0800, 1'b1);
    expect_all("R6", 32'h0000_0100, 1'b0, 1'b1, 1'b1, 1'b1);
    apply(1'b0, 2'd0, 32'd0, 1'b1);
    expect_all("R6", 32'h0000_0400, 1'b1, 1'b1, 1'b1, 1'b1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule